// File: doc/BRIEF.md
# NFC Target Wake-Up and Protocol Selector

This block is the control sequencer of an NFC target or tag-emulation front end. It compares a digitized RF field level against a threshold set by the host. When the field rises above that threshold, it forces the device awake and waits for the supply and oscillator to report stable. It then raises an interrupt, waits for the first initiator command, and raises a second interrupt. At that second interrupt it publishes the target mode and bit rate chosen from the type and coding of the command.

The first command arrives as decoded flags from an upstream receiver: a command kind, the rate it arrived at, and the host's tag-emulation control bit. The host must assert its enable between the two interrupts. Otherwise the device falls back to monitoring once the second interrupt has been raised. The block also tells the transmit path whether RF collision avoidance has to run before a reply.

Top module: `nfc_tgt_wake`

## Requirements
- R1: After a synchronous reset, `awake_o`, `irq_o`, `ca_req_o`, `status_o`, `irq_flags_o` and `proto_o` are all zero.
- R2: A threshold of zero disables monitoring. No RF level wakes the block, and an awake block returns to monitoring one cycle after the threshold becomes zero.
- R3: With a nonzero threshold, an RF level strictly above it sets `awake_o` one cycle later. A level equal to the threshold does not.
- R4: When `pwr_stable_i` is high while powering up, the next cycle shows `status_o[6]` (oscillator ok) set and a one-cycle `irq_o` pulse.
- R5: When `cmd_valid_i` is high while waiting for the first command, the next cycle shows `irq_o` high and `irq_flags_o[6]` set. In that same cycle, `proto_o` holds the selected protocol whenever the block stays awake. `proto_o` is {mode[2:0], rate[1:0]}, and the rate codes are 00=106, 01=212 and 10=424 kbit/s.
- R6: A polling request (`cmd_kind_i`=01) selects passive target mode 001. Its rate is 10 if the command arrived at 424 kbit/s and 01 otherwise.
- R7: An ATR request (`cmd_kind_i`=10) selects active target mode 010 at the command's own rate. It also sets `ca_req_o`, so that collision avoidance comes before transmission.
- R8: An ISO14443B-coded command (`cmd_kind_i`=11) with `tag_emu_i` set selects emulation mode 011 at rate 00. In passive and emulation modes `ca_req_o` stays low.
- R9: If `host_en_i` is low when the second interrupt is raised, the block returns to monitoring. `awake_o` then falls and `proto_o` is zero.
- R10: If the field drops to or below the threshold while the block is awake, it returns to monitoring on the next cycle, with `proto_o` cleared.
- R11: An unrecognized first command sets `status_o[0]` (error), leaves `proto_o` at zero and returns to monitoring. A command is unrecognized when `cmd_kind_i`=00, when it is ISO14443B-coded without `tag_emu_i`, or when `cmd_rate_i`=11. The error bit is cleared at the next wake-up.
- R12: Once a target mode is selected, dropping `host_en_i` returns the block to monitoring on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh_i | input | LVL_W | Detection threshold; zero disables monitoring |
| rf_level_i | input | LVL_W | Digitized RF field level |
| host_en_i | input | 1 | Host enable that keeps the device awake |
| pwr_stable_i | input | 1 | Supply and oscillator report stable |
| cmd_valid_i | input | 1 | First initiator command received (one cycle) |
| cmd_kind_i | input | 2 | 00 other, 01 polling, 10 ATR request, 11 ISO14443B-coded |
| cmd_rate_i | input | 2 | Rate the command arrived at (00/01/10, 11 invalid) |
| tag_emu_i | input | 1 | Tag-emulation control bit |
| awake_o | output | 1 | Device is powered (not monitoring) |
| irq_o | output | 1 | Interrupt pulse |
| status_o | output | 8 | Bit 6 oscillator ok, bit 0 error |
| irq_flags_o | output | 8 | Bit 6 first command received |
| proto_o | output | 5 | Target protocol {mode, rate} |
| ca_req_o | output | 1 | Collision avoidance required before transmit |

## Verification
The bench builds the block with an 8-bit level width. This keeps the threshold edges directly reachable: zero, a level equal to the threshold, one step above it, and the full-scale value 255. A fixed-seed random loop runs complete wake-up sequences. Each sequence draws its command kind, arrival rate, emulation bit, host enable and an optional field drop at random. This covers every protocol code, including the reserved rate 11 and the field-drop race with the second interrupt.

// File: rtl/nfc_tgt_pkg.sv
package nfc_tgt_pkg;
  typedef enum logic [1:0] {ST_MON, ST_PWR, ST_WAIT, ST_TGT} wake_st_t;

  localparam logic [1:0] KIND_OTHER = 2'b00;
  localparam logic [1:0] KIND_POLL  = 2'b01;
  localparam logic [1:0] KIND_ATR   = 2'b10;
  localparam logic [1:0] KIND_ISOB  = 2'b11;

  localparam logic [1:0] RATE_106 = 2'b00;
  localparam logic [1:0] RATE_212 = 2'b01;
  localparam logic [1:0] RATE_424 = 2'b10;
  localparam logic [1:0] RATE_BAD = 2'b11;

  localparam logic [2:0] MODE_NONE    = 3'b000;
  localparam logic [2:0] MODE_PASSIVE = 3'b001;
  localparam logic [2:0] MODE_ACTIVE  = 3'b010;
  localparam logic [2:0] MODE_EMU_B   = 3'b011;

  localparam int PROTO_W = 5;
  localparam int REG_W   = 8;
  localparam int OSC_BIT = 6;
  localparam int ERR_BIT = 0;
  localparam int CMD_BIT = 6;
endpackage

// File: rtl/nfc_field_cmp.sv
module nfc_field_cmp #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] thresh_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             field_ok_o
);
  logic armed;
  assign armed      = |thresh_i;
  assign field_ok_o = armed && (level_i > thresh_i);
endmodule

// File: rtl/nfc_cmd_decode.sv
module nfc_cmd_decode
  import nfc_tgt_pkg::*;
(
  input  logic [1:0]         kind_i,
  input  logic [1:0]         rate_i,
  input  logic               tag_emu_i,
  output logic               known_o,
  output logic [PROTO_W-1:0] proto_o
);
  logic [2:0] mode;
  logic [1:0] rate;

  always_comb begin
    mode = MODE_NONE;
    rate = RATE_106;
    if (rate_i != RATE_BAD) begin
      unique case (kind_i)
        KIND_POLL: begin
          mode = MODE_PASSIVE;
          rate = (rate_i == RATE_424) ? RATE_424 : RATE_212;
        end
        KIND_ATR: begin
          mode = MODE_ACTIVE;
          rate = rate_i;
        end
        KIND_ISOB: begin
          if (tag_emu_i) begin
            mode = MODE_EMU_B;
            rate = RATE_106;
          end
        end
        default: mode = MODE_NONE;
      endcase
    end
  end

  assign known_o = (mode != MODE_NONE);
  assign proto_o = {mode, rate};
endmodule

// File: rtl/nfc_tgt_wake.sv
module nfc_tgt_wake
  import nfc_tgt_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LVL_W-1:0]   thresh_i,
  input  logic [LVL_W-1:0]   rf_level_i,
  input  logic               host_en_i,
  input  logic               pwr_stable_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_kind_i,
  input  logic [1:0]         cmd_rate_i,
  input  logic               tag_emu_i,
  output logic               awake_o,
  output logic               irq_o,
  output logic [REG_W-1:0]   status_o,
  output logic [REG_W-1:0]   irq_flags_o,
  output logic [PROTO_W-1:0] proto_o,
  output logic               ca_req_o
);
  wake_st_t           st;
  logic               field_ok;
  logic               cmd_known;
  logic [PROTO_W-1:0] cmd_proto;

  nfc_field_cmp #(.LVL_W(LVL_W)) u_cmp (
    .thresh_i  (thresh_i),
    .level_i   (rf_level_i),
    .field_ok_o(field_ok)
  );

  nfc_cmd_decode u_dec (
    .kind_i   (cmd_kind_i),
    .rate_i   (cmd_rate_i),
    .tag_emu_i(tag_emu_i),
    .known_o  (cmd_known),
    .proto_o  (cmd_proto)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_MON;
      awake_o     <= 1'b0;
      irq_o       <= 1'b0;
      status_o    <= '0;
      irq_flags_o <= '0;
      proto_o     <= '0;
      ca_req_o    <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (st != ST_MON && !field_ok) begin
        st                <= ST_MON;
        awake_o           <= 1'b0;
        proto_o           <= '0;
        ca_req_o          <= 1'b0;
        status_o[OSC_BIT] <= 1'b0;
      end else begin
        unique case (st)
          ST_MON: begin
            if (field_ok) begin
              st          <= ST_PWR;
              awake_o     <= 1'b1;
              status_o    <= '0;
              irq_flags_o <= '0;
            end
          end
          ST_PWR: begin
            if (pwr_stable_i) begin
              st                <= ST_WAIT;
              status_o[OSC_BIT] <= 1'b1;
              irq_o             <= 1'b1;
            end
          end
          ST_WAIT: begin
            if (cmd_valid_i) begin
              irq_o                <= 1'b1;
              irq_flags_o[CMD_BIT] <= 1'b1;
              if (cmd_known && host_en_i) begin
                st       <= ST_TGT;
                proto_o  <= cmd_proto;
                ca_req_o <= (cmd_proto[PROTO_W-1 -: 3] == MODE_ACTIVE);
              end else begin
                st                <= ST_MON;
                awake_o           <= 1'b0;
                status_o[OSC_BIT] <= 1'b0;
                if (!cmd_known) status_o[ERR_BIT] <= 1'b1;
              end
            end
          end
          ST_TGT: begin
            if (!host_en_i) begin
              st                <= ST_MON;
              awake_o           <= 1'b0;
              proto_o           <= '0;
              ca_req_o          <= 1'b0;
              status_o[OSC_BIT] <= 1'b0;
            end
          end
          default: st <= ST_MON;
        endcase
      end
    end
  end
endmodule

// File: rtl/nfc_tgt_wake_chk.sv
module nfc_tgt_wake_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] thresh_i,
  input logic [LVL_W-1:0] rf_level_i,
  input logic             awake_o,
  input logic             irq_o,
  input logic [7:0]       status_o,
  input logic [7:0]       irq_flags_o,
  input logic [4:0]       proto_o,
  input logic             ca_req_o
);
  // R2
  thresh_zero_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (thresh_i == '0) |=> (!awake_o && proto_o == '0));

  // R4
  osc_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[6]) |-> irq_o);

  // R5
  cmd_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flags_o[6]) |-> irq_o);

  // R7
  ca_active_only_chk: assert property (@(posedge clk) disable iff (rst)
    ca_req_o |-> (proto_o[4:2] == 3'b010));

  // R10
  field_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (awake_o && rf_level_i <= thresh_i) |=> (!awake_o && proto_o == '0));

  // R9
  proto_needs_awake_chk: assert property (@(posedge clk) disable iff (rst)
    (proto_o != '0) |-> awake_o);
endmodule

bind nfc_tgt_wake nfc_tgt_wake_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .thresh_i   (thresh_i),
  .rf_level_i (rf_level_i),
  .awake_o    (awake_o),
  .irq_o      (irq_o),
  .status_o   (status_o),
  .irq_flags_o(irq_flags_o),
  .proto_o    (proto_o),
  .ca_req_o   (ca_req_o)
);

// File: tb/sim_nfc_tgt_wake.sv
module sim_nfc_tgt_wake;
  localparam int LVL_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LVL_W-1:0] thresh_i = '0;
  logic [LVL_W-1:0] rf_level_i = '0;
  logic             host_en_i = 1'b0;
  logic             pwr_stable_i = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [1:0]       cmd_kind_i = '0;
  logic [1:0]       cmd_rate_i = '0;
  logic             tag_emu_i = 1'b0;
  logic             awake_o, irq_o, ca_req_o;
  logic [7:0]       status_o, irq_flags_o;
  logic [4:0]       proto_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  nfc_tgt_wake #(.LVL_W(LVL_W)) u0 (
    .clk(clk), .rst(rst), .thresh_i(thresh_i), .rf_level_i(rf_level_i),
    .host_en_i(host_en_i), .pwr_stable_i(pwr_stable_i), .cmd_valid_i(cmd_valid_i),
    .cmd_kind_i(cmd_kind_i), .cmd_rate_i(cmd_rate_i), .tag_emu_i(tag_emu_i),
    .awake_o(awake_o), .irq_o(irq_o), .status_o(status_o),
    .irq_flags_o(irq_flags_o), .proto_o(proto_o), .ca_req_o(ca_req_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected protocol code from the requirement table, 0 when unrecognized
  function automatic logic [4:0] exp_proto(logic [1:0] k, logic [1:0] r, logic e);
    if (r == 2'b11) return 5'b0;
    case (k)
      2'b01: return {3'b001, (r == 2'b10) ? 2'b10 : 2'b01};
      2'b10: return {3'b010, r};
      2'b11: return e ? {3'b011, 2'b00} : 5'b0;
      default: return 5'b0;
    endcase
  endfunction

  // full wake-up; drop=1 removes the field in the command cycle
  task automatic wake_seq(logic [1:0] k, logic [1:0] r, logic e, logic en, logic drop);
    logic [4:0] p;
    p = exp_proto(k, r, e);
    thresh_i = 8'd40; rf_level_i = 8'd100; host_en_i = 1'b0;
    step();
    chk("R3 wake", awake_o, 1);
    pwr_stable_i = 1'b1;
    step();
    pwr_stable_i = 1'b0;
    chk("R4 osc_ok", status_o[6], 1);
    chk("R4 irq", irq_o, 1);
    cmd_valid_i = 1'b1; cmd_kind_i = k; cmd_rate_i = r; tag_emu_i = e; host_en_i = en;
    if (drop) rf_level_i = 8'd40;
    step();
    cmd_valid_i = 1'b0;
    if (drop) begin
      chk("R10 drop awake", awake_o, 0);
      chk("R10 drop proto", proto_o, 0);
    end else begin
      chk("R5 irq", irq_o, 1);
      chk("R5 flag", irq_flags_o[6], 1);
      if (p == 5'b0) begin
        chk("R11 err", status_o[0], 1);
        chk("R11 proto", proto_o, 0);
        chk("R11 awake", awake_o, 0);
      end else if (!en) begin
        chk("R9 awake", awake_o, 0);
        chk("R9 proto", proto_o, 0);
        chk("R9 err", status_o[0], 0);
      end else begin
        chk("R6 R7 R8 proto", proto_o, p);
        chk("R7 R8 ca_req", ca_req_o, p[4:2] == 3'b010);
        chk("R5 awake", awake_o, 1);
      end
    end
    step();
    chk("R4 R5 irq pulse", irq_o, 0);
    rf_level_i = 8'd0;
    step();
    chk("R10 back to monitor", awake_o, 0);
    chk("R10 proto cleared", proto_o, 0);
    host_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(); step();
    rst = 1'b0;
    step();
    chk("R1 awake", awake_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 flags", irq_flags_o, 0);
    chk("R1 proto", proto_o, 0);
    chk("R1 ca", ca_req_o, 0);

    // R2: zero threshold never wakes
    thresh_i = 8'd0; rf_level_i = 8'd255;
    step(); step();
    chk("R2 disabled", awake_o, 0);
    // R3: equal does not wake, one above does
    thresh_i = 8'd50; rf_level_i = 8'd50;
    step(); step();
    chk("R3 equal", awake_o, 0);
    rf_level_i = 8'd51;
    step();
    chk("R3 above", awake_o, 1);
    // R2: threshold to zero while awake
    thresh_i = 8'd0;
    step();
    chk("R2 disarm", awake_o, 0);
    rf_level_i = 8'd0;
    step();

    // directed protocols
    wake_seq(2'b01, 2'b01, 1'b0, 1'b1, 1'b0); // R6 212
    wake_seq(2'b01, 2'b10, 1'b0, 1'b1, 1'b0); // R6 424
    wake_seq(2'b10, 2'b00, 1'b0, 1'b1, 1'b0); // R7
    wake_seq(2'b11, 2'b01, 1'b1, 1'b1, 1'b0); // R8
    wake_seq(2'b11, 2'b00, 1'b0, 1'b1, 1'b0); // R11
    wake_seq(2'b10, 2'b11, 1'b0, 1'b1, 1'b0); // R11 bad rate
    wake_seq(2'b01, 2'b00, 1'b0, 1'b0, 1'b0); // R9

    // R11: error cleared at next wake
    thresh_i = 8'd40; rf_level_i = 8'd100;
    step();
    chk("R11 err clear", status_o[0], 0);
    // R12: host enable drop in target
    pwr_stable_i = 1'b1; step(); pwr_stable_i = 1'b0;
    cmd_valid_i = 1'b1; cmd_kind_i = 2'b10; cmd_rate_i = 2'b10; host_en_i = 1'b1;
    step(); cmd_valid_i = 1'b0;
    chk("R7 active 424", proto_o, 5'b01010);
    host_en_i = 1'b0;
    step();
    chk("R12 awake", awake_o, 0);
    chk("R12 proto", proto_o, 0);
    rf_level_i = 8'd0;
    step();

    for (int i = 0; i < 300; i++) begin
      wake_seq(2'($urandom), 2'($urandom), 1'($urandom),
               ($urandom % 4) != 0, ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule